// File: doc/BRIEF.md
# Gated Observe FIFO with Threshold Interrupt

This block holds raw entropy samples in a 64-word by 32-bit queue so that firmware can pull them out one word at a time. A producer pushes samples with a one-cycle write strobe. Firmware pops words with a read strobe, and the popped word appears on the read data port one cycle later. The read side is guarded by an 8-bit multi-bit enable that normally comes from one-time-programmable fuses. While that enable does not hold its "true" code, read strobes return zero and leave the queue untouched.

A level-sensitive interrupt tells firmware that at least a programmed number of words is waiting. A threshold of zero disables the interrupt. There are three sticky error flags: one for pushing into a full queue, one for an enabled pop from an empty queue, and one for an occupancy counter that no longer agrees with the read and write pointers. A synchronous clear pulse resets all three flags.

Top module: `obsq_gated`

## Requirements
- R1: After a synchronous reset the queue is empty, `thr_irq` is low, all three error flags are low and `rd_data` reads zero.
- R2: Words are returned in the order they were written. An accepted read strobe in cycle N places the oldest word on `rd_data` from cycle N+1 onward, and `rd_data` holds that word until the next read strobe.
- R3: A write strobe while 64 words are held discards the sample and sets `err_overflow` from the next cycle. The queue contents are unchanged.
- R4: A read strobe while the enable holds the true code and the queue is empty sets `err_underflow` from the next cycle and makes `rd_data` read zero.
- R5: The true code of `fw_rd_en` is 8'h96. Any other value, including the false code 8'h69, turns a read strobe into a blocked read. A blocked read makes `rd_data` zero on the next cycle, removes no word and does not set `err_underflow`.
- R6: For `irq_thresh` between 1 and 63, `thr_irq` is high in every cycle in which the occupancy is at least `irq_thresh`.
- R7: While `irq_thresh` is 0, `thr_irq` stays low at every occupancy, including a full queue.
- R8: `thr_irq` drops in the first cycle in which the occupancy is below the threshold, with no extra register delay after the pop edge.
- R9: Every error flag stays set until `err_clr` is high at a clock edge. That edge clears all three flags. A new error in the same cycle wins over the clear.
- R10: If the occupancy count disagrees with the difference of the 7-bit write and read pointers, or exceeds 64, `err_state` is set from the next cycle.
- R11: When a write and an accepted read happen in the same cycle, the occupancy is unchanged and word order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Push strobe for one sample |
| wr_data | input | 32 | Sample to push |
| rd_req | input | 1 | Pop strobe from firmware |
| rd_data | output | 32 | Popped word, or zero after a blocked or empty read |
| irq_thresh | input | 6 | Interrupt occupancy threshold; 0 disables |
| fw_rd_en | input | 8 | Multi-bit read enable; 8'h96 opens the read path |
| thr_irq | output | 1 | Level interrupt: occupancy at or above threshold |
| err_clr | input | 1 | Synchronous clear of all error flags |
| err_overflow | output | 1 | Sticky: write attempted while full |
| err_underflow | output | 1 | Sticky: enabled read attempted while empty |
| err_state | output | 1 | Sticky: occupancy and pointers disagree |

## Verification
The clocked properties assume that every input is a clean synchronous level held for whole cycles, and that reset is held for at least one edge before any strobe is given. The stimulus meets this by changing inputs only on the falling edge. The hold-level property for simultaneous push and pop also assumes that the occupancy register is changed only by the block's own logic. For that reason the deliberate corruption used to provoke `err_state` is applied only on cycles with no strobes, and it is followed by a reset. Threshold and enable values change only while no strobe is active, so the interrupt and gating checks see stable configuration.

// File: rtl/obsq_pkg.sv
package obsq_pkg;

  // Multi-bit code that opens the firmware read path; all other codes block it.
  localparam logic [7:0] MUBI8_ON = 8'h96;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic bad;
  } obsq_err_t;

endpackage

// File: rtl/obsq_ram.sv
module obsq_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read with enable: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/obsq_gate.sv
module obsq_gate #(
  parameter int             EN_W    = 8,
  parameter logic [EN_W-1:0] ON_CODE = obsq_pkg::MUBI8_ON
) (
  input  logic [EN_W-1:0] en_code,
  output logic            open_o
);
  // Exact match only; any corrupted or false code keeps the path shut.
  assign open_o = (en_code == ON_CODE);

endmodule

// File: rtl/obsq_ctrl.sv
module obsq_ctrl
  import obsq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              rd_req,
  input  logic              gate_open,
  input  logic              err_clr,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   level,
  output obsq_err_t         err
);
  localparam int          PW    = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << ADDR_W);

  logic [PW-1:0] wp_q, rp_q, cnt_q, cnt_d;
  logic          full, empty, state_bad;
  obsq_err_t     err_q, err_set;

  assign full  = (cnt_q == DEPTH);
  assign empty = (cnt_q == '0);

  assign wr_ok = wr_valid && !full;
  assign rd_ok = rd_req && gate_open && !empty;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok && !rd_ok) cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (rd_ok) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_d;
    end
  end

  // Redundant occupancy check: the count must match the pointer distance.
  assign state_bad = (cnt_q > DEPTH) || (cnt_q != PW'(wp_q - rp_q));

  assign err_set.ovf = wr_valid && full;
  assign err_set.unf = rd_req && gate_open && empty;
  assign err_set.bad = state_bad;

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (err_clr ? '0 : err_q) | err_set;
  end

  assign waddr = wp_q[ADDR_W-1:0];
  assign raddr = rp_q[ADDR_W-1:0];
  assign level = cnt_q;
  assign err   = err_q;

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && level == DEPTH) |=> err.ovf);

  p_unf_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && gate_open && level == '0) |=> err.unf);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (err.ovf && !err_clr) |=> err.ovf);

  p_level_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && rd_ok) |=> $stable(level));

endmodule

// File: rtl/obsq_gated.sv
module obsq_gated
  import obsq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int THR_W  = 6,
  parameter int EN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  input  logic [THR_W-1:0]  irq_thresh,
  input  logic [EN_W-1:0]   fw_rd_en,
  output logic              thr_irq,
  input  logic              err_clr,
  output logic              err_overflow,
  output logic              err_underflow,
  output logic              err_state
);
  localparam int CW = (THR_W > ADDR_W + 1) ? THR_W : ADDR_W + 1;

  logic              gate_open, wr_ok, rd_ok;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W:0]   level;
  logic [DATA_W-1:0] ram_q;
  logic              rd_zero_q;
  obsq_err_t         err;

  obsq_gate #(.EN_W(EN_W), .ON_CODE(EN_W'(MUBI8_ON))) u_gate (
    .en_code (fw_rd_en),
    .open_o  (gate_open)
  );

  obsq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .rd_req    (rd_req),
    .gate_open (gate_open),
    .err_clr   (err_clr),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .waddr     (waddr),
    .raddr     (raddr),
    .level     (level),
    .err       (err)
  );

  obsq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (rd_ok),
    .raddr (raddr),
    .rdata (ram_q)
  );

  // Blocked or empty reads return zero; the RAM output register is left alone.
  always_ff @(posedge clk) begin
    if (rst)         rd_zero_q <= 1'b1;
    else if (rd_req) rd_zero_q <= !rd_ok;
  end

  assign rd_data = rd_zero_q ? '0 : ram_q;

  // Level interrupt straight off the occupancy register; threshold 0 disables.
  assign thr_irq = (irq_thresh != '0) && (CW'(level) >= CW'(irq_thresh));

  assign err_overflow  = err.ovf;
  assign err_underflow = err.unf;
  assign err_state     = err.bad;

  p_gate_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !gate_open) |=> (rd_data == '0));

  p_gate_no_unf_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !gate_open && !err.unf && !err_clr) |=> !err.unf);

endmodule

// File: tb/obsq_gated_bench.sv
module obsq_gated_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_data;
  logic [5:0]  irq_thresh = '0;
  logic [7:0]  fw_rd_en = 8'h96;
  logic        thr_irq;
  logic        err_clr = 1'b0;
  logic        err_overflow, err_underflow, err_state;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  obsq_gated u_obsq_gated (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .irq_thresh(irq_thresh),
    .fw_rd_en(fw_rd_en), .thr_irq(thr_irq), .err_clr(err_clr),
    .err_overflow(err_overflow), .err_underflow(err_underflow),
    .err_state(err_state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic clear_errs();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq", 32'(thr_irq), 0);
    check("R1 errs", {29'd0, err_overflow, err_underflow, err_state}, 0);
    check("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    irq_thresh = 6'd0;
    for (int i = 0; i < 5; i++) push(32'h1234_0000 + 32'(i * 7));
    check("R7 thresh0 irq", 32'(thr_irq), 0);
    for (int i = 0; i < 5; i++) begin
      pop();
      check("R2 order", rd_data, 32'h1234_0000 + 32'(i * 7));
    end
    @(negedge clk);
    check("R2 hold", rd_data, 32'h1234_001C);
  endtask

  task automatic t_thresh();
    irq_thresh = 6'd3;
    push(32'hB0); push(32'hB1);
    check("R6 below", 32'(thr_irq), 0);
    push(32'hB2);
    check("R6 reached", 32'(thr_irq), 1);
    pop();
    check("R8 drop", 32'(thr_irq), 0);
    check("R2 first", rd_data, 32'hB0);
    pop(); pop();
    irq_thresh = 6'd0;
  endtask

  task automatic t_gate();
    push(32'hC0FFEE01);
    fw_rd_en = 8'h69;
    pop();
    check("R5 false code data", rd_data, 0);
    check("R5 no unf", 32'(err_underflow), 0);
    fw_rd_en = 8'h00;
    pop();
    check("R5 other code data", rd_data, 0);
    fw_rd_en = 8'h96;
    pop();
    check("R5 word kept", rd_data, 32'hC0FFEE01);
  endtask

  task automatic t_underflow();
    pop();
    check("R4 unf flag", 32'(err_underflow), 1);
    check("R4 zero data", rd_data, 0);
    repeat (3) @(negedge clk);
    check("R9 sticky", 32'(err_underflow), 1);
    clear_errs();
    check("R9 cleared", 32'(err_underflow), 0);
  endtask

  task automatic t_overflow();
    int errs = 0;
    irq_thresh = 6'd63;
    for (int i = 0; i < 63; i++) push(32'hA000_0000 + 32'(i));
    check("R6 at 63", 32'(thr_irq), 1);
    push(32'hA000_003F);
    check("R3 no ovf yet", 32'(err_overflow), 0);
    push(32'hDEAD_BEEF);
    check("R3 ovf flag", 32'(err_overflow), 1);
    irq_thresh = 6'd0;
    @(negedge clk);
    check("R7 full thresh0", 32'(thr_irq), 0);
    for (int i = 0; i < 64; i++) begin
      pop();
      if (rd_data !== 32'hA000_0000 + 32'(i)) errs++;
    end
    check("R3 contents kept", 32'(errs), 0);
    check("R3 unf clean", 32'(err_underflow), 0);
    pop();
    check("R3 dropped word", rd_data, 0);
    check("R9 ovf still set", 32'(err_overflow), 1);
    clear_errs();
    check("R9 all clear", {30'd0, err_overflow, err_underflow}, 0);
  endtask

  task automatic t_simul();
    irq_thresh = 6'd2;
    push(32'hE1); push(32'hE2);
    check("R11 irq before", 32'(thr_irq), 1);
    wr_valid = 1'b1; wr_data = 32'hE3; rd_req = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_req = 1'b0;
    check("R11 oldest out", rd_data, 32'hE1);
    check("R11 level kept", 32'(thr_irq), 1);
    pop();
    check("R11 order 2", rd_data, 32'hE2);
    check("R8 below", 32'(thr_irq), 0);
    pop();
    check("R11 order 3", rd_data, 32'hE3);
    irq_thresh = 6'd0;
  endtask

  task automatic t_state();
    do_reset();
    check("R10 clean", 32'(err_state), 0);
    force u_obsq_gated.u_ctrl.cnt_q = 7'd5;
    @(negedge clk);
    release u_obsq_gated.u_ctrl.cnt_q;
    check("R10 bad state", 32'(err_state), 1);
    check("R10 only state", {30'd0, err_overflow, err_underflow}, 0);
    do_reset();
    check("R1 state cleared", 32'(err_state), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_thresh();
    t_gate();
    t_underflow();
    t_overflow();
    t_simul();
    t_state();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule